// File: doc/BRIEF.md
# DTMF Tone Pair Synthesizer

This block turns a 4-bit digit code into the digital sample streams of a dual-tone multi-frequency signal. It is clocked from a 3.579545 MHz master clock. Each of the two tones has its own programmable divider. The divider counts master clocks up to a segment length picked by the code. At the end of each segment it advances a 5-bit segment index that walks a 32-step sine table. One tone period is therefore 32 segments long, and pitch depends only on the segment length.

The row (low group) and column (high group) samples come out as signed words. A third output is their sum, with the column sample boosted by a fixed gain of 81/64 (about +2 dB) and saturated to the output width. A single-tone mode keeps only one group running, either row or column. Dropping the tone enable parks both generators at segment 0, so every burst starts at phase zero. A one-cycle strobe per tone marks the end of each full period.

Top module: `dtmf_synth`

## Requirements
- R1: The code selects a row segment length and a column segment length: code 1..3 → row 160; 4..6 → row 146; 7..9 → row 132; 10, 11, 12 and 0 → row 118; 13, 14, 15 → rows 160, 146, 132. Columns: codes 1,4,7,11 → 92; 2,5,8,10 → 84; 3,6,9,12 → 76; 13,14,15,0 → 68.
- R2: While enabled, a tone's segment index advances by one every L master clocks, where L is its segment length, and wraps modulo 32.
- R3: A tone sample equals round-to-within-1-LSB of (32767/2^(16−SAMPLE_W))·sin(2π·s/32) for segment index s. It is zero at s = 0 and negative for s = 17..31.
- R4: A tone's wrap strobe is high for exactly the last master clock of segment 31, once every 32·L clocks.
- R5: The mixed output equals row + floor(col·81/64), saturated to the signed OUT_W range.
- R6: With the tone enable low, both samples, the mixed output and both strobes are zero after the next clock edge.
- R7: After the enable rises, both tones start at segment 0 and first advance after exactly L clocks, whatever phase they held before.
- R8: In single-tone mode with the group select at 0, only the row tone runs. The column sample stays zero and its strobe stays low.
- R9: In single-tone mode with the group select at 1, only the column tone runs. The row sample stays zero and its strobe stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 3.579545 MHz master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| digit | input | 4 | Digit code selecting the tone pair |
| tone_en | input | 1 | Tone output enable |
| single_tone | input | 1 | 1 = generate only one group |
| group_sel | input | 1 | In single-tone mode: 0 = row, 1 = column |
| row_smp | output | SAMPLE_W | Signed row (low group) sample |
| col_smp | output | SAMPLE_W | Signed column (high group) sample |
| mix_out | output | OUT_W | Saturated sum with column pre-emphasis |
| row_wrap | output | 1 | Row tone period-end strobe |
| col_wrap | output | 1 | Column tone period-end strobe |

## Verification
The samples and strobes are decoded without registers from the segment counters. After n clock edges with the enable high, each sample is therefore due as the sine of floor(n/L) mod 32, and a strobe is due in the cycle where n mod 32L equals 32L−1. The bench drives inputs on falling edges and compares every output one time unit later, each cycle, against that count. A disable takes effect at the first rising edge after it. The zero checks start one edge later, and the restart checks count edges again from zero.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;
  localparam int SEG_W = 5;
  localparam int DIV_W = 8;
  localparam int NUM_GRP = 2;

  typedef logic [1:0] tone_idx_t;

  // segment lengths in master clocks, low group then high group
  function automatic logic [DIV_W-1:0] seg_len(input logic grp, input tone_idx_t idx);
    logic [DIV_W-1:0] len;
    if (!grp) begin
      case (idx)
        2'd0:    len = 8'd160;
        2'd1:    len = 8'd146;
        2'd2:    len = 8'd132;
        default: len = 8'd118;
      endcase
    end else begin
      case (idx)
        2'd0:    len = 8'd92;
        2'd1:    len = 8'd84;
        2'd2:    len = 8'd76;
        default: len = 8'd68;
      endcase
    end
    return len;
  endfunction

  // quarter sine in Q15, points k*pi/16 for k = 0..8
  function automatic logic [15:0] quarter_sine(input logic [3:0] k);
    logic [15:0] v;
    case (k)
      4'd0:    v = 16'd0;
      4'd1:    v = 16'd6393;
      4'd2:    v = 16'd12539;
      4'd3:    v = 16'd18204;
      4'd4:    v = 16'd23170;
      4'd5:    v = 16'd27245;
      4'd6:    v = 16'd30273;
      4'd7:    v = 16'd32137;
      default: v = 16'd32767;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/dtmf_code_map.sv
module dtmf_code_map
  import dtmf_pkg::*;
(
  input  logic [3:0] digit,
  output tone_idx_t  row_idx,
  output tone_idx_t  col_idx
);
  always_comb begin
    case (digit)
      4'd1:    begin row_idx = 2'd0; col_idx = 2'd0; end
      4'd2:    begin row_idx = 2'd0; col_idx = 2'd1; end
      4'd3:    begin row_idx = 2'd0; col_idx = 2'd2; end
      4'd4:    begin row_idx = 2'd1; col_idx = 2'd0; end
      4'd5:    begin row_idx = 2'd1; col_idx = 2'd1; end
      4'd6:    begin row_idx = 2'd1; col_idx = 2'd2; end
      4'd7:    begin row_idx = 2'd2; col_idx = 2'd0; end
      4'd8:    begin row_idx = 2'd2; col_idx = 2'd1; end
      4'd9:    begin row_idx = 2'd2; col_idx = 2'd2; end
      4'd10:   begin row_idx = 2'd3; col_idx = 2'd1; end
      4'd11:   begin row_idx = 2'd3; col_idx = 2'd0; end
      4'd12:   begin row_idx = 2'd3; col_idx = 2'd2; end
      4'd13:   begin row_idx = 2'd0; col_idx = 2'd3; end
      4'd14:   begin row_idx = 2'd1; col_idx = 2'd3; end
      4'd15:   begin row_idx = 2'd2; col_idx = 2'd3; end
      default: begin row_idx = 2'd3; col_idx = 2'd3; end
    endcase
  end
endmodule

// File: rtl/dtmf_tone_gen.sv
module dtmf_tone_gen
  import dtmf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] seg_len_i,
  output logic [SEG_W-1:0] seg_o,
  output logic             wrap_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [SEG_W-1:0] seg_q, seg_d;
  logic             term;

  // terminal when the count reaches length-1 (>= copes with a shrinking length)
  assign term = (cnt_q >= (seg_len_i - DIV_W'(1)));

  always_comb begin
    cnt_d = cnt_q;
    seg_d = seg_q;
    if (!run) begin
      cnt_d = '0;
      seg_d = '0;
    end else if (term) begin
      cnt_d = '0;
      seg_d = seg_q + SEG_W'(1);
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      seg_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      seg_q <= seg_d;
    end
  end

  assign seg_o  = seg_q;
  assign wrap_o = run & term & (&seg_q);
endmodule

// File: rtl/dtmf_sine_rom.sv
module dtmf_sine_rom
  import dtmf_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic [SEG_W-1:0]           seg,
  output logic signed [SAMPLE_W-1:0] sample
);
  localparam int SHIFT = 16 - SAMPLE_W;

  logic [3:0]          k;
  logic [15:0]         q15;
  logic [SAMPLE_W-1:0] mag;

  // fold the 32 segments onto the 9-point quarter wave
  assign k   = seg[3] ? (4'd8 - {1'b0, seg[2:0]}) : {1'b0, seg[2:0]};
  assign q15 = quarter_sine(k);
  assign mag = SAMPLE_W'(q15 >> SHIFT);
  assign sample = seg[4] ? -$signed(mag) : $signed(mag);
endmodule

// File: rtl/dtmf_mix.sv
module dtmf_mix #(
  parameter int SAMPLE_W = 12,
  parameter int OUT_W    = 13,
  parameter int GAIN_NUM = 81,
  parameter int GAIN_SH  = 6
) (
  input  logic signed [SAMPLE_W-1:0] row_s,
  input  logic signed [SAMPLE_W-1:0] col_s,
  output logic signed [OUT_W-1:0]    mix
);
  localparam int GAIN_W = $clog2(GAIN_NUM + 1) + 1;
  localparam int PROD_W = SAMPLE_W + GAIN_W;
  localparam int WIDE_W = PROD_W + 1;
  localparam logic signed [PROD_W-1:0] GAIN_S = PROD_W'(GAIN_NUM);
  localparam logic signed [WIDE_W-1:0] MAX_V  = WIDE_W'((64'sd1 <<< (OUT_W - 1)) - 1);
  localparam logic signed [WIDE_W-1:0] MIN_V  = -MAX_V - WIDE_W'(1);

  logic signed [PROD_W-1:0] col_ext, prod, boosted;
  logic signed [WIDE_W-1:0] wide;

  always_comb begin
    col_ext = PROD_W'(col_s);
    prod    = col_ext * GAIN_S;
    boosted = prod >>> GAIN_SH;
    wide    = WIDE_W'(row_s) + WIDE_W'(boosted);
    if (wide > MAX_V)      mix = MAX_V[OUT_W-1:0];
    else if (wide < MIN_V) mix = MIN_V[OUT_W-1:0];
    else                   mix = wide[OUT_W-1:0];
  end
endmodule

// File: rtl/dtmf_synth.sv
module dtmf_synth
  import dtmf_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int OUT_W    = 13,
  parameter int GAIN_NUM = 81,
  parameter int GAIN_SH  = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [3:0]                 digit,
  input  logic                       tone_en,
  input  logic                       single_tone,
  input  logic                       group_sel,
  output logic signed [SAMPLE_W-1:0] row_smp,
  output logic signed [SAMPLE_W-1:0] col_smp,
  output logic signed [OUT_W-1:0]    mix_out,
  output logic                       row_wrap,
  output logic                       col_wrap
);
  logic                     rst_meta, rst_sync;
  tone_idx_t                row_idx, col_idx;
  tone_idx_t                grp_idx  [NUM_GRP];
  logic                     grp_run  [NUM_GRP];
  logic [SEG_W-1:0]         grp_seg  [NUM_GRP];
  logic                     grp_wrap [NUM_GRP];
  logic signed [SAMPLE_W-1:0] grp_smp [NUM_GRP];

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  dtmf_code_map u_map (
    .digit   (digit),
    .row_idx (row_idx),
    .col_idx (col_idx)
  );

  assign grp_idx[0] = row_idx;
  assign grp_idx[1] = col_idx;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_tone
    // a group runs when enabled and not excluded by single-tone mode
    assign grp_run[g] = tone_en & (~single_tone | (group_sel == g[0]));

    dtmf_tone_gen u_gen (
      .clk       (clk),
      .rst_n     (rst_sync),
      .run       (grp_run[g]),
      .seg_len_i (seg_len(g[0], grp_idx[g])),
      .seg_o     (grp_seg[g]),
      .wrap_o    (grp_wrap[g])
    );

    dtmf_sine_rom #(.SAMPLE_W(SAMPLE_W)) u_rom (
      .seg    (grp_seg[g]),
      .sample (grp_smp[g])
    );
  end

  dtmf_mix #(
    .SAMPLE_W (SAMPLE_W),
    .OUT_W    (OUT_W),
    .GAIN_NUM (GAIN_NUM),
    .GAIN_SH  (GAIN_SH)
  ) u_mix (
    .row_s (grp_smp[0]),
    .col_s (grp_smp[1]),
    .mix   (mix_out)
  );

  assign row_smp  = grp_smp[0];
  assign col_smp  = grp_smp[1];
  assign row_wrap = grp_wrap[0];
  assign col_wrap = grp_wrap[1];
endmodule

// File: rtl/dtmf_synth_chk.sv
module dtmf_synth_chk #(
  parameter int SAMPLE_W = 12,
  parameter int OUT_W    = 13
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       tone_en,
  input logic                       single_tone,
  input logic                       group_sel,
  input logic signed [SAMPLE_W-1:0] row_smp,
  input logic signed [SAMPLE_W-1:0] col_smp,
  input logic signed [OUT_W-1:0]    mix_out,
  input logic                       row_wrap,
  input logic                       col_wrap
);
  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_en |=> (!tone_en |-> (row_smp == 0 && col_smp == 0 && mix_out == 0)));

  // R4
  row_wrap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_wrap |=> row_smp == 0);

  // R4
  col_wrap_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_wrap |=> col_smp == 0);

  // R8
  row_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (single_tone && !group_sel) |=> ((single_tone && !group_sel) |-> (col_smp == 0 && !col_wrap)));

  // R9
  col_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (single_tone && group_sel) |=> ((single_tone && group_sel) |-> (row_smp == 0 && !row_wrap)));

  // R6
  wrap_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_wrap || col_wrap) |-> tone_en);
endmodule

bind dtmf_synth dtmf_synth_chk #(.SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tone_en     (tone_en),
  .single_tone (single_tone),
  .group_sel   (group_sel),
  .row_smp     (row_smp),
  .col_smp     (col_smp),
  .mix_out     (mix_out),
  .row_wrap    (row_wrap),
  .col_wrap    (col_wrap)
);

// File: tb/tb_dtmf_synth.sv
`timescale 1ns/1ps
module tb_dtmf_synth;
  localparam int SAMPLE_W = 12;
  localparam int OUT_W    = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] digit = 4'd0;
  logic tone_en = 1'b0, single_tone = 1'b0, group_sel = 1'b0;
  logic signed [SAMPLE_W-1:0] row_smp, col_smp;
  logic signed [OUT_W-1:0] mix_out;
  logic row_wrap, col_wrap;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dtmf_synth #(.SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W)) dut (
    .clk(clk), .rst_n(rst_n), .digit(digit), .tone_en(tone_en),
    .single_tone(single_tone), .group_sel(group_sel),
    .row_smp(row_smp), .col_smp(col_smp), .mix_out(mix_out),
    .row_wrap(row_wrap), .col_wrap(col_wrap));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // realized tone frequencies per requirement R1 table
  function automatic real row_freq(input int d);
    case (d)
      1, 2, 3, 13: return 699.1;
      4, 5, 6, 14: return 766.2;
      7, 8, 9, 15: return 847.4;
      default:     return 948.0;
    endcase
  endfunction

  function automatic real col_freq(input int d);
    case (d)
      1, 4, 7, 11: return 1215.9;
      2, 5, 8, 10: return 1331.7;
      3, 6, 9, 12: return 1471.9;
      default:     return 1645.0;
    endcase
  endfunction

  function automatic int seg_of(input real f);
    return $rtoi(3579545.0 / (32.0 * f) + 0.5);
  endfunction

  function automatic real sine_exp(input int s);
    return (32767.0 / real'(1 << (16 - SAMPLE_W))) * $sin(2.0 * 3.14159265358979 * real'(s) / 32.0);
  endfunction

  function automatic bit near(input int a, input real e);
    real d;
    d = real'(a) - e;
    return (d <= 1.0) && (d >= -1.0);
  endfunction

  function automatic int mix_exp(input int r, input int c);
    int v, hi, lo;
    v  = r + ((c * 81) >>> 6);
    hi = (1 << (OUT_W - 1)) - 1;
    lo = -(1 << (OUT_W - 1));
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  // drive at a falling edge, then check every cycle for ncyc edges
  task automatic run_tone(input int d, input bit sgl, input bit sel, input int ncyc);
    int rl, cl, rs, cs;
    bit r_on, c_on, ew;
    rl = seg_of(row_freq(d));
    cl = seg_of(col_freq(d));
    r_on = !(sgl && sel);
    c_on = !(sgl && !sel);
    digit = 4'(d); single_tone = sgl; group_sel = sel; tone_en = 1'b1;
    for (int n = 0; n < ncyc; n++) begin
      #1;
      rs = (n / rl) % 32;
      cs = (n / cl) % 32;
      // R1 R2 R3 R7 R8 R9
      if (r_on) chk(near(int'(row_smp), sine_exp(rs)), "R2/R3 row sample", int'(row_smp), $rtoi(sine_exp(rs)));
      else      chk(row_smp == 0, "R9 row held", int'(row_smp), 0);
      if (c_on) chk(near(int'(col_smp), sine_exp(cs)), "R1/R3 col sample", int'(col_smp), $rtoi(sine_exp(cs)));
      else      chk(col_smp == 0, "R8 col held", int'(col_smp), 0);
      // R5
      chk(int'(mix_out) == mix_exp(int'(row_smp), int'(col_smp)), "R5 mix", int'(mix_out),
          mix_exp(int'(row_smp), int'(col_smp)));
      // R4
      ew = r_on && ((n % (32 * rl)) == 32 * rl - 1);
      chk(row_wrap == ew, "R4 row strobe", int'(row_wrap), int'(ew));
      ew = c_on && ((n % (32 * cl)) == 32 * cl - 1);
      chk(col_wrap == ew, "R4 col strobe", int'(col_wrap), int'(ew));
      @(negedge clk);
    end
  endtask

  // R6: disable, then outputs must be zero after the next edge
  task automatic idle(input int ncyc);
    tone_en = 1'b0;
    @(negedge clk);
    for (int n = 0; n < ncyc; n++) begin
      #1;
      chk(row_smp == 0 && col_smp == 0, "R6 samples off", int'(row_smp) | int'(col_smp), 0);
      chk(mix_out == 0, "R6 mix off", int'(mix_out), 0);
      chk(!row_wrap && !col_wrap, "R6 strobes off", int'(row_wrap) + int'(col_wrap), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(row_smp == 0 && col_smp == 0 && mix_out == 0, "R6 reset state", int'(mix_out), 0);
    chk(!row_wrap && !col_wrap, "R6 reset strobes", int'(row_wrap) + int'(col_wrap), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: every code, one full row period (covers at least one column period)
    for (int d = 0; d < 16; d++) begin
      run_tone(d, 1'b0, 1'b0, 32 * seg_of(row_freq(d)) + 4);
      idle(2);
    end

    // R7: stop mid-tone, restart from segment 0
    run_tone(6, 1'b0, 1'b0, 777);
    idle(5);
    run_tone(6, 1'b0, 1'b0, 600);
    idle(2);

    // R8: row only
    run_tone(5, 1'b1, 1'b0, 32 * 146 + 2);
    idle(2);
    // R9: column only
    run_tone(5, 1'b1, 1'b1, 32 * 84 + 2);
    idle(3);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule